// File: doc/BRIEF.md
# DMA Channel Termination and Size-Error Controller

This block sits beside the byte counter of one DMA channel and decides when the channel stops. Software loads a byte count and an enable bit, and also supplies an access width, a transfer mode, a block or cluster length and the interrupt enables. The block then answers each incoming request in one cycle. It reports how many bytes the current transfer unit carries, pulses an accept strobe and decrements the count by that amount.

The channel stops in one of two ways. It stops normally when a transfer drains the count to zero. It is aborted when the size check is enabled and a request arrives while the remaining count is shorter than a full unit. When the size check is off, a short remainder is drained with smaller transfers, down to single bytes. Completion and error flags stay set until software clears them. Each interrupt request output is its flag gated by the matching enable.

Top module: `dma_end_ctrl`

## Requirements
- R1: After reset the count is 0, and the enable, active, both flags and both interrupt outputs are 0.
- R2: A configuration write loads the count and the enable. On the following cycle the active output is 1 exactly when the written enable is 1 and the written count is nonzero.
- R3: In normal mode (mode_i=0) and repeat mode (mode_i=1), the unit size is the access width when the count is at least that width, and 1 byte otherwise. The access width is 1, 2 or 4 bytes for acc_size_i = 0, 1 or 2.
- R4: In block mode (mode_i=2) and cluster mode (mode_i=3), the unit size depends on the count and the unit length:
  - when the count is at least unit_len_i, the unit size is unit_len_i;
  - otherwise, when the count is at least the access width, the unit size is the count rounded down to a multiple of the access width;
  - otherwise, the unit size is 1 byte.
- R5: Every accepted request (xfer_o=1) lowers the count by the unit size shown in that cycle.
- R6: When an accepted transfer brings the count to 0, the enable and active outputs go to 0 and the completion flag goes to 1 on the next cycle.
- R7: If the channel is enabled with a count of 0, requests move no data. The completion flag stays 0 and the enable stays 1.
- R8: With the size check on in normal or repeat mode, a request while the count is below the access width is not accepted. The count is kept, and on the next cycle the enable and active outputs are 0 and the error flag is 1.
- R9: With the size check on in block or cluster mode, a request while the count is below unit_len_i aborts the channel in the same way as R8.
- R10: With the size check off, the error flag never rises, and requests drain the count to 0.
- R11: done_irq_o equals the completion flag ANDed with done_ie_i, and err_irq_o equals the error flag ANDed with err_ie_i.
- R12: Each flag stays 1 until its clear input is pulsed. After the pulse it reads 0.
- R13: While the enable is 0, requests are ignored: xfer_o stays 0 and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the count and the enable |
| cfg_en_i | input | 1 | Enable value to load |
| cfg_count_i | input | CNT_W | Byte count to load |
| mode_i | input | 2 | 0 normal, 1 repeat, 2 block, 3 cluster |
| acc_size_i | input | 2 | Access width: 0=1, 1=2, 2=4 bytes |
| unit_len_i | input | CNT_W | Block or cluster length in bytes |
| err_chk_i | input | 1 | Size check enable |
| done_ie_i | input | 1 | Completion interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| done_clr_i | input | 1 | Clear the completion flag |
| err_clr_i | input | 1 | Clear the error flag |
| req_i | input | 1 | Transfer request |
| xfer_o | output | 1 | Request accepted this cycle |
| xfer_size_o | output | CNT_W | Bytes in the current unit |
| count_o | output | CNT_W | Remaining byte count |
| en_o | output | 1 | Channel enable |
| act_o | output | 1 | Channel active |
| done_flag_o | output | 1 | Completion flag |
| err_flag_o | output | 1 | Size-error flag |
| done_irq_o | output | 1 | Completion interrupt request |
| err_irq_o | output | 1 | Size-error interrupt request |

## Verification
The assertions assume three things about the configuration:
- unit_len_i is nonzero and a multiple of the access width;
- acc_size_i never takes the value 3;
- the configuration is held steady while the channel is active.

They also assume that a configuration write and a request do not arrive in the same cycle. The stimulus keeps a fixed unit length of 8. It sweeps every mode, every legal access width, both settings of the size check and counts from 0 to 19. It changes the configuration only while the channel is idle and always drops the request before issuing a write.

// File: rtl/dma_end_pkg.sv
package dma_end_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_BLOCK   = 2'd2,
    MODE_CLUSTER = 2'd3
  } xfer_mode_e;

  localparam int unsigned ACC_W = 2;
endpackage

// File: rtl/dma_unit_sizer.sv
module dma_unit_sizer
  import dma_end_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       mode_i,
  input  logic [ACC_W-1:0] acc_size_i,
  input  logic [CNT_W-1:0] unit_len_i,
  output logic [CNT_W-1:0] size_o,
  output logic             short_o
);
  logic [CNT_W-1:0] acc_bytes;
  logic [CNT_W-1:0] acc_mask;
  logic             below_acc;
  logic             below_unit;
  logic             grouped;

  always_comb begin
    unique case (acc_size_i)
      2'd0:    acc_bytes = CNT_W'(1);
      2'd1:    acc_bytes = CNT_W'(2);
      default: acc_bytes = CNT_W'(4);
    endcase
  end

  assign acc_mask   = ~(acc_bytes - CNT_W'(1));
  assign below_acc  = count_i < acc_bytes;
  assign below_unit = count_i < unit_len_i;
  assign grouped    = (mode_i == MODE_BLOCK) || (mode_i == MODE_CLUSTER);

  always_comb begin
    if (!grouped) begin
      size_o = below_acc ? CNT_W'(1) : acc_bytes;
    end else if (!below_unit) begin
      size_o = unit_len_i;
    end else if (!below_acc) begin
      size_o = count_i & acc_mask;
    end else begin
      size_o = CNT_W'(1);
    end
  end

  // residual shorter than the unit a request expects
  assign short_o = grouped ? below_unit : below_acc;
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] dec_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (load_i) begin
      count_o <= load_val_i;
    end else if (dec_i) begin
      count_o <= count_o - dec_val_i;
    end
  end

  assign last_o = (count_o == dec_val_i);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_en_i,
  input  logic cfg_nz_i,
  input  logic xfer_i,
  input  logic last_i,
  input  logic err_hit_i,
  input  logic done_clr_i,
  input  logic err_clr_i,
  output logic en_o,
  output logic act_o,
  output logic done_flag_o,
  output logic err_flag_o
);
  logic fin;
  assign fin = xfer_i && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      act_o <= 1'b0;
    end else if (cfg_we_i) begin
      en_o  <= cfg_en_i;
      act_o <= cfg_en_i && cfg_nz_i;
    end else if (fin || err_hit_i) begin
      en_o  <= 1'b0;
      act_o <= 1'b0;
    end
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_flag_o <= 1'b0;
      err_flag_o  <= 1'b0;
    end else begin
      if (fin)             done_flag_o <= 1'b1;
      else if (done_clr_i) done_flag_o <= 1'b0;
      if (err_hit_i)       err_flag_o  <= 1'b1;
      else if (err_clr_i)  err_flag_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_end_ctrl.sv
module dma_end_ctrl
  import dma_end_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       acc_size_i,
  input  logic [CNT_W-1:0] unit_len_i,
  input  logic             err_chk_i,
  input  logic             done_ie_i,
  input  logic             err_ie_i,
  input  logic             done_clr_i,
  input  logic             err_clr_i,
  input  logic             req_i,
  output logic             xfer_o,
  output logic [CNT_W-1:0] xfer_size_o,
  output logic [CNT_W-1:0] count_o,
  output logic             en_o,
  output logic             act_o,
  output logic             done_flag_o,
  output logic             err_flag_o,
  output logic             done_irq_o,
  output logic             err_irq_o
);
  logic short_res;
  logic last_unit;
  logic err_hit;
  logic live_req;

  dma_unit_sizer #(.CNT_W(CNT_W)) u_sizer (
    .count_i    (count_o),
    .mode_i     (mode_i),
    .acc_size_i (acc_size_i),
    .unit_len_i (unit_len_i),
    .size_o     (xfer_size_o),
    .short_o    (short_res)
  );

  assign live_req = req_i && act_o && !cfg_we_i;
  assign err_hit  = live_req && err_chk_i && short_res;
  assign xfer_o   = live_req && !err_hit;

  dma_byte_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_we_i),
    .load_val_i (cfg_count_i),
    .dec_i      (xfer_o),
    .dec_val_i  (xfer_size_o),
    .count_o    (count_o),
    .last_o     (last_unit)
  );

  dma_chan_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_nz_i    (|cfg_count_i),
    .xfer_i      (xfer_o),
    .last_i      (last_unit),
    .err_hit_i   (err_hit),
    .done_clr_i  (done_clr_i),
    .err_clr_i   (err_clr_i),
    .en_o        (en_o),
    .act_o       (act_o),
    .done_flag_o (done_flag_o),
    .err_flag_o  (err_flag_o)
  );

  assign done_irq_o = done_flag_o && done_ie_i;
  assign err_irq_o  = err_flag_o && err_ie_i;
endmodule

module dma_end_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             req_i,
  input logic             err_chk_i,
  input logic             done_clr_i,
  input logic             xfer_o,
  input logic [CNT_W-1:0] xfer_size_o,
  input logic [CNT_W-1:0] count_o,
  input logic             en_o,
  input logic             act_o,
  input logic             done_flag_o,
  input logic             err_flag_o
);
  AST_END_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !cfg_we_i && count_o == xfer_size_o) |=> (!en_o && !act_o && done_flag_o)); // R6

  AST_DEC_BY_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !cfg_we_i) |=> (count_o == $past(count_o) - $past(xfer_size_o))); // R5

  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> (!en_o && !act_o)); // R8

  AST_NO_ERR_UNCHECKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_chk_i |=> !$rose(err_flag_o)); // R10

  AST_IDLE_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !cfg_we_i) |=> $stable(count_o)); // R13

  AST_UNIT_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (xfer_size_o <= count_o && xfer_size_o != '0)); // R3

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_flag_o && !done_clr_i) |=> done_flag_o); // R12
endmodule

bind dma_end_ctrl dma_end_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .req_i       (req_i),
  .err_chk_i   (err_chk_i),
  .done_clr_i  (done_clr_i),
  .xfer_o      (xfer_o),
  .xfer_size_o (xfer_size_o),
  .count_o     (count_o),
  .en_o        (en_o),
  .act_o       (act_o),
  .done_flag_o (done_flag_o),
  .err_flag_o  (err_flag_o)
);

// File: tb/dma_end_ctrl_tb.sv
`timescale 1ns/1ps
module dma_end_ctrl_tb;
  localparam int CNT_W = 16;
  localparam int UNIT  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic             cfg_en_i = 1'b0;
  logic [CNT_W-1:0] cfg_count_i = '0;
  logic [1:0]       mode_i = '0;
  logic [1:0]       acc_size_i = '0;
  logic [CNT_W-1:0] unit_len_i = CNT_W'(UNIT);
  logic             err_chk_i = 1'b0;
  logic             done_ie_i = 1'b0;
  logic             err_ie_i = 1'b0;
  logic             done_clr_i = 1'b0;
  logic             err_clr_i = 1'b0;
  logic             req_i = 1'b0;
  logic             xfer_o;
  logic [CNT_W-1:0] xfer_size_o;
  logic [CNT_W-1:0] count_o;
  logic             en_o, act_o, done_flag_o, err_flag_o, done_irq_o, err_irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_end_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_en_i, .cfg_count_i, .mode_i, .acc_size_i,
    .unit_len_i, .err_chk_i, .done_ie_i, .err_ie_i, .done_clr_i, .err_clr_i,
    .req_i, .xfer_o, .xfer_size_o, .count_o, .en_o, .act_o, .done_flag_o,
    .err_flag_o, .done_irq_o, .err_irq_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_size(input int m, input int a, input int c);
    int ab;
    ab = 1 << a;
    if (m < 2) return (c >= ab) ? ab : 1;
    if (c >= UNIT) return UNIT;
    if (c >= ab) return (c / ab) * ab;
    return 1;
  endfunction

  task automatic cfg_write(input bit en, input int cnt);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_en_i = en; cfg_count_i = CNT_W'(cnt);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_i);
    done_clr_i = 1'b1; err_clr_i = 1'b1;
    @(negedge clk_i);
    done_clr_i = 1'b0; err_clr_i = 1'b0;
    chk(!done_flag_o && !err_flag_o, "R12 flags cleared", {done_flag_o, err_flag_o}, 0);
  endtask

  task automatic run_case(input int m, input int a, input bit ec, input int c);
    int cnt;
    bit ended;
    int thr, sz;
    mode_i = 2'(m); acc_size_i = 2'(a); err_chk_i = ec;
    done_ie_i = c[0]; err_ie_i = c[1];
    cfg_write(1'b1, c);
    chk(en_o == 1'b1, "R2 enable loaded", en_o, 1);
    chk(act_o == (c != 0), "R2 active", act_o, c != 0);
    cnt = c;
    ended = 1'b0;
    thr = (m < 2) ? (1 << a) : UNIT;
    for (int step = 0; step < 25 && !ended; step++) begin
      req_i = 1'b1;
      #2;
      if (cnt == 0) begin
        chk(xfer_o == 1'b0, "R7 no move at zero", xfer_o, 0);
        @(negedge clk_i); req_i = 1'b0;
        chk(count_o == 0 && !done_flag_o && en_o, "R7 no end at zero",
            {count_o, done_flag_o, en_o}, 1);
        ended = 1'b1;
      end else if (ec && cnt < thr) begin
        chk(xfer_o == 1'b0, m < 2 ? "R8 short rejected" : "R9 short rejected", xfer_o, 0);
        @(negedge clk_i); req_i = 1'b0;
        chk(err_flag_o && !en_o && !act_o,
            m < 2 ? "R8 abort" : "R9 abort", {err_flag_o, en_o, act_o}, 4);
        chk(count_o == cnt, m < 2 ? "R8 count kept" : "R9 count kept", count_o, cnt);
        chk(!done_flag_o, "R8 no completion", done_flag_o, 0);
        chk(err_irq_o == err_ie_i, "R11 err irq", err_irq_o, err_ie_i);
        ended = 1'b1;
      end else begin
        sz = exp_size(m, a, cnt);
        chk(xfer_o == 1'b1, "R5 accept", xfer_o, 1);
        chk(xfer_size_o == sz, m < 2 ? "R3 unit size" : "R4 unit size", xfer_size_o, sz);
        @(negedge clk_i); req_i = 1'b0;
        cnt -= sz;
        chk(count_o == cnt, "R5 decrement", count_o, cnt);
        if (cnt == 0) begin
          chk(done_flag_o && !en_o && !act_o, "R6 normal end",
              {done_flag_o, en_o, act_o}, 4);
          chk(!err_flag_o, "R10 no error", err_flag_o, 0);
          chk(done_irq_o == done_ie_i, "R11 done irq", done_irq_o, done_ie_i);
          ended = 1'b1;
        end
      end
    end
    if (!ec && c != 0)
      chk(count_o == 0 && !err_flag_o, "R10 drained", count_o, 0);
    @(negedge clk_i);
    chk(done_flag_o == (c != 0 && cnt == 0), "R12 done sticky", done_flag_o, c != 0 && cnt == 0);
    clear_flags();
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #45;
    chk(count_o == 0 && !en_o && !act_o, "R1 reset state", {count_o, en_o, act_o}, 0);
    chk(!done_flag_o && !err_flag_o && !done_irq_o && !err_irq_o, "R1 reset flags",
        {done_flag_o, err_flag_o, done_irq_o, err_irq_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R13: disabled channel ignores requests
    cfg_write(1'b0, 5);
    chk(!act_o, "R2 no active when disabled", act_o, 0);
    req_i = 1'b1; #2;
    chk(xfer_o == 1'b0, "R13 no accept", xfer_o, 0);
    @(negedge clk_i); @(negedge clk_i); req_i = 1'b0;
    chk(count_o == 5, "R13 count held", count_o, 5);

    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 3; a++)
        for (int e = 0; e < 2; e++)
          for (int c = 0; c < 20; c++)
            run_case(m, a, e[0], c);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule